// File: doc/BRIEF.md
# DDR Bank Timing Guard

This block sits beside a DDR SDRAM command scheduler for a four-bank device and answers one question every cycle: may the command presented now be sent to the memory? It tracks which banks hold an activated row, stores that row per bank, and runs cycle countdown timers for every inter-command spacing the device imposes. This covers per-bank spacings (activate to column access, activate to precharge, activate to activate, precharge recovery, write recovery) and device-wide spacings (activate to activate across banks, refresh recovery, mode load recovery).

The scheduler presents `cmd_i`, `bank_i` and `row_i` with `cmd_valid_i`. `grant_o` is combinational from the current state and the presented command. A command counts as issued on a clock edge where both `cmd_valid_i` and `grant_o` are high, and only issued commands change state. Each timer loads ceiling(t/tCK) - 1 on the command that starts it and counts down to zero. A dependent command is therefore granted exactly ceiling(t/tCK) cycles after the starting command.

Command encoding on `cmd_i`: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 LOAD MODE. With the default 8 ns clock the cycle counts are: RCD 2, RAS 5, RC 7, RRD 2, RP 2, write recovery 2 plus a 2-cycle data tail (4 after the WRITE), RFC 9, MRD 2.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset all four banks are closed, every stored row is zero, and a NOP (code 0) is granted.
- R2: ACTIVATE (code 1) is granted only to a closed bank. When issued, it sets that bank's bit in `open_mask_o` and stores `row_i` in that bank's slice of `open_row_o`.
- R3: READ (2) or WRITE (3) to a bank whose `open_mask_o` bit is clear is never granted.
- R4: READ or WRITE to an open bank is denied until 2 cycles (RCD) after its ACTIVATE, and is granted from then on.
- R5: PRECHARGE (4) of a bank is denied until 5 cycles (RAS) after its ACTIVATE, and until 4 cycles (write recovery plus data tail) after its last WRITE.
- R6: ACTIVATE of a bank is denied until 2 cycles (RP) after its PRECHARGE and 7 cycles (RC) after its previous ACTIVATE.
- R7: ACTIVATE is denied until 2 cycles (RRD) after the previous ACTIVATE to any bank.
- R8: PRECHARGE with `row_i[10]`=1 waits for all open banks, then closes all banks and restarts every bank's RP timer. With `row_i[10]`=0 it closes and restarts only the addressed bank, which may already be closed.
- R9: REFRESH (5) is granted only when all banks are closed and past RP and RC. For 9 cycles (RFC) after it, REFRESH, LOAD MODE, PRECHARGE and ACTIVATE are denied.
- R10: LOAD MODE (6) is granted only when all banks are closed. For 2 cycles (MRD) after it, ACTIVATE and REFRESH are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A candidate command is presented |
| cmd_i | input | 3 | Candidate command code |
| bank_i | input | 2 | Target bank |
| row_i | input | 13 | Row address; bit 10 selects all banks on PRECHARGE |
| grant_o | output | 1 | Candidate is legal this cycle |
| open_mask_o | output | 4 | One bit per bank, set while a row is open |
| open_row_o | output | 52 | Open row per bank, bank n at bits [13n+12:13n] |

## Verification
`grant_o` is combinational, so it is sampled one time step after inputs are driven at the falling edge, in the same cycle. `open_mask_o` and `open_row_o` change at the rising edge that issues a command and are checked just after that edge. Each scenario task steps one command per cycle and counts cycles from the starting command. Each timing limit is probed in the last denied cycle and in the first granted cycle, so a timer that is off by one in either direction shows up.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  // value loaded into a down-counter so that the dependent command is
  // granted ceil(t/tck) cycles after the starting one
  function automatic int cyc_load(int t_ps, int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n > 0) ? n - 1 : 0;
  endfunction
endpackage

// File: rtl/ddr_cnt_timer.sv
module ddr_cnt_timer #(
  parameter int LOAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int CW = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(LOAD);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4..R10 rely on monotonic countdown between loads
  a_r4_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ddr_bank_ctx.sv
module ddr_bank_ctx #(
  parameter int ROW_W = 13,
  parameter int L_RCD = 1,
  parameter int L_RAS = 4,
  parameter int L_RC  = 6,
  parameter int L_RP  = 1,
  parameter int L_WR  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             wr_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             pre_ok_o,
  output logic             rc_ok_o,
  output logic             rp_ok_o
);
  logic open_q;
  logic [ROW_W-1:0] row_q;
  logic ras_ok, wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  ddr_cnt_timer #(.LOAD(L_RCD)) u_rcd (.clk_i, .rst_ni, .load_i(act_i), .zero_o(rcd_ok_o));
  ddr_cnt_timer #(.LOAD(L_RAS)) u_ras (.clk_i, .rst_ni, .load_i(act_i), .zero_o(ras_ok));
  ddr_cnt_timer #(.LOAD(L_RC))  u_rc  (.clk_i, .rst_ni, .load_i(act_i), .zero_o(rc_ok_o));
  ddr_cnt_timer #(.LOAD(L_RP))  u_rp  (.clk_i, .rst_ni, .load_i(pre_i), .zero_o(rp_ok_o));
  ddr_cnt_timer #(.LOAD(L_WR))  u_wr  (.clk_i, .rst_ni, .load_i(wr_i),  .zero_o(wr_ok));

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign pre_ok_o = ras_ok & wr_ok;

  a_r2_act_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q);
  a_r5_pre_after_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && open_q) |-> (ras_ok && wr_ok));
endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
  import ddr_guard_pkg::*;
#(
  parameter int CLK_PS    = 8000,
  parameter int ROW_W     = 13,
  parameter int NUM_BANKS = 4,
  parameter int AP_BIT    = 10,
  parameter int T_RCD_PS  = 15000,
  parameter int T_RAS_PS  = 40000,
  parameter int T_RC_PS   = 55000,
  parameter int T_RRD_PS  = 10000,
  parameter int T_RP_PS   = 15000,
  parameter int T_WR_PS   = 15000,
  parameter int T_RFC_PS  = 70000,
  parameter int T_MRD_PS  = 10000,
  parameter int WR_TAIL   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_i,
  input  logic [BA_W-1:0]            bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic                       grant_o,
  output logic [NUM_BANKS-1:0]       open_mask_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
  localparam int L_RCD = cyc_load(T_RCD_PS, CLK_PS);
  localparam int L_RAS = cyc_load(T_RAS_PS, CLK_PS);
  localparam int L_RC  = cyc_load(T_RC_PS,  CLK_PS);
  localparam int L_RRD = cyc_load(T_RRD_PS, CLK_PS);
  localparam int L_RP  = cyc_load(T_RP_PS,  CLK_PS);
  localparam int L_WR  = cyc_load(T_WR_PS,  CLK_PS) + WR_TAIL;
  localparam int L_RFC = cyc_load(T_RFC_PS, CLK_PS);
  localparam int L_MRD = cyc_load(T_MRD_PS, CLK_PS);

  cmd_e cmd;
  logic issue, all_ap;
  logic [NUM_BANKS-1:0] sel, open_m, rcd_ok, pre_ok, rc_ok, rp_ok;
  logic [NUM_BANKS-1:0] act_b, wr_b, pre_b;
  logic rrd_ok, rfc_ok, mrd_ok;

  assign cmd    = cmd_e'(cmd_i);
  assign sel    = NUM_BANKS'(1) << bank_i;
  assign issue  = cmd_valid_i & grant_o;
  assign all_ap = row_i[AP_BIT];

  always_comb begin
    grant_o = 1'b0;
    unique case (cmd)
      CMD_NOP: grant_o = 1'b1;
      CMD_ACT: grant_o = ~open_m[bank_i] & rc_ok[bank_i] & rp_ok[bank_i]
                         & rrd_ok & rfc_ok & mrd_ok;
      CMD_RD,
      CMD_WR:  grant_o = open_m[bank_i] & rcd_ok[bank_i];
      CMD_PRE: grant_o = rfc_ok & (all_ap ? (&(~open_m | pre_ok))
                                          : (~open_m[bank_i] | pre_ok[bank_i]));
      CMD_REF: grant_o = (open_m == '0) & (&rp_ok) & (&rc_ok) & rfc_ok & mrd_ok;
      CMD_MRS: grant_o = (open_m == '0) & (&rp_ok) & rfc_ok & mrd_ok;
      default: grant_o = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign act_b[g] = issue & (cmd == CMD_ACT) & sel[g];
    assign wr_b[g]  = issue & (cmd == CMD_WR)  & sel[g];
    assign pre_b[g] = issue & (cmd == CMD_PRE) & (all_ap | sel[g]);

    ddr_bank_ctx #(
      .ROW_W(ROW_W), .L_RCD(L_RCD), .L_RAS(L_RAS),
      .L_RC(L_RC), .L_RP(L_RP), .L_WR(L_WR)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i   (act_b[g]),
      .wr_i    (wr_b[g]),
      .pre_i   (pre_b[g]),
      .row_i   (row_i),
      .open_o  (open_m[g]),
      .row_o   (open_row_o[g*ROW_W +: ROW_W]),
      .rcd_ok_o(rcd_ok[g]),
      .pre_ok_o(pre_ok[g]),
      .rc_ok_o (rc_ok[g]),
      .rp_ok_o (rp_ok[g])
    );
  end

  ddr_cnt_timer #(.LOAD(L_RRD)) u_rrd (.clk_i, .rst_ni,
    .load_i(issue & (cmd == CMD_ACT)), .zero_o(rrd_ok));
  ddr_cnt_timer #(.LOAD(L_RFC)) u_rfc (.clk_i, .rst_ni,
    .load_i(issue & (cmd == CMD_REF)), .zero_o(rfc_ok));
  ddr_cnt_timer #(.LOAD(L_MRD)) u_mrd (.clk_i, .rst_ni,
    .load_i(issue & (cmd == CMD_MRS)), .zero_o(mrd_ok));

  assign open_mask_o = open_m;

  a_r3_rw_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && (cmd == CMD_RD || cmd == CMD_WR)) |-> open_m[bank_i]);
  a_r8_pre_all_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && cmd == CMD_PRE && all_ap) |=> (open_m == '0));
  a_r9_ref_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && cmd == CMD_REF) |-> (open_m == '0));
  a_r10_mrs_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && cmd == CMD_MRS) |-> (open_m == '0));
endmodule

// File: tb/tb_ddr_bank_guard.sv
module tb_ddr_bank_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [1:0] bank = '0;
  logic [12:0] row = '0;
  logic grant;
  logic [3:0] mask;
  logic [51:0] rows;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, REF = 5, MRS = 6;

  always #4 clk = ~clk;

  ddr_bank_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd),
    .bank_i(bank), .row_i(row), .grant_o(grant),
    .open_mask_o(mask), .open_row_o(rows)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: present command, check grant, let edge issue it
  task automatic try(logic [2:0] c, logic [1:0] b, logic [12:0] r, logic exp, string tag);
    @(negedge clk);
    valid = 1'b1; cmd = c; bank = b; row = r;
    #1 chk(tag, 32'(grant), 32'(exp));
    @(posedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid = 1'b0; cmd = NOP;
      @(posedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 mask", 32'(mask), 0);
    chk("R1 rows", 32'(rows[31:0] | rows[51:32]), 0);
    try(NOP, 0, 0, 1, "R1 nop");
  endtask

  // c0 ACT b0; RCD=2, RAS=5, RC=7, WR+tail=4, RP=2
  task automatic t_bank0;
    try(ACT, 0, 13'h123, 1, "R2 act b0");            // c0
    chk("R2 mask", 32'(mask), 32'h1);
    chk("R2 row0", 32'(rows[12:0]), 32'h123);
    try(RD, 0, 0, 0, "R4 rd early");                  // c1
    try(RD, 0, 0, 1, "R4 rd ok");                     // c2
    try(WR, 0, 0, 1, "R4 wr ok");                     // c3
    try(PRE, 0, 0, 0, "R5 pre ras");                  // c4
    try(ACT, 0, 0, 0, "R2 act open bank");            // c5
    try(PRE, 0, 0, 0, "R5 pre wr recovery");          // c6
    try(PRE, 0, 0, 1, "R5 pre ok");                   // c7
    chk("R8 single close", 32'(mask), 0);
    try(ACT, 0, 0, 0, "R6 act rp");                   // c8
    try(ACT, 0, 13'h0AA, 1, "R6 act ok");             // c9
  endtask

  task automatic t_rrd;
    try(ACT, 1, 13'h1F0, 0, "R7 act b1 early");       // c10
    try(ACT, 1, 13'h1F0, 1, "R7 act b1");             // c11
    try(ACT, 2, 13'h0F2, 0, "R7 act b2 early");       // c12
    try(ACT, 2, 13'h0F2, 1, "R7 act b2");             // c13
    try(RD, 3, 0, 0, "R3 rd closed");                 // c14
    chk("R2 mask three", 32'(mask), 32'h7);
    chk("R2 row1", 32'(rows[25:13]), 32'h1F0);
    chk("R2 row2", 32'(rows[38:26]), 32'h0F2);
  endtask

  task automatic t_pre;
    try(PRE, 0, 13'h400, 0, "R8 all wait b2");        // c15
    idle(2);                                          // c16,c17
    try(PRE, 0, 13'h400, 1, "R8 all ok");             // c18
    chk("R8 all closed", 32'(mask), 0);
    try(ACT, 3, 13'h003, 0, "R6 rp after all");       // c19
    try(ACT, 3, 13'h003, 1, "R6 act b3");             // c20
    try(PRE, 0, 13'h000, 1, "R8 pre closed b0");      // c21
    chk("R8 only addressed", 32'(mask), 32'h8);
    try(WR, 0, 0, 0, "R3 wr closed");                 // c22
  endtask

  task automatic t_ref_mrs;
    try(REF, 0, 0, 0, "R9 ref open bank");            // c23
    try(NOP, 0, 0, 1, "R3 nop");                      // c24
    try(PRE, 3, 0, 1, "R5 pre b3");                   // c25
    try(REF, 0, 0, 0, "R9 ref rp");                   // c26
    try(REF, 0, 0, 1, "R9 ref ok");                   // c27
    try(MRS, 0, 0, 0, "R9 mrs rfc");                  // c28
    try(ACT, 1, 0, 0, "R9 act rfc");                  // c29
    idle(4);                                          // c30..c33
    try(PRE, 1, 0, 0, "R9 pre rfc");                  // c34
    try(REF, 0, 0, 0, "R9 ref rfc");                  // c35
    try(MRS, 0, 0, 1, "R10 mrs ok");                  // c36
    try(ACT, 0, 13'h077, 0, "R10 act mrd");           // c37
    try(ACT, 0, 13'h077, 1, "R10 act ok");            // c38
    chk("R2 row0 new", 32'(rows[12:0]), 32'h077);
    try(MRS, 0, 0, 0, "R10 mrs open bank");           // c39
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bank0();
    t_rrd();
    t_pre();
    t_ref_mrs();
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule